// File: doc/BRIEF.md
# Per-Line Table DMA Engine

This engine runs eight independent channels. Each channel walks a table in memory and, once per display line, pushes a short burst of bytes from memory to the B peripheral port. The table holds entries that start with a line-count byte. Bit 7 of that byte is a repeat flag, which asks for a fresh transfer on every line. Bits 6..0 give the number of lines before the next entry is read. In indirect mode, an entry also carries a 16-bit data pointer, and the bytes are taken from that pointer combined with a separate per-channel bank.

Two commands drive the engine. An init command at frame start loads each enabled channel's table pointer and reads its first entry. A run command, issued once per line, first moves one unit of bytes for every channel with a transfer pending. It then ages every active channel's line counter and reads a new entry where one is due. Any channel that the engine touches tells the shared burst sequencer to cancel its own burst, through a one-cycle mask. While the engine works, `busy` tells the burst sequencer to pause. Each command ends with a short interrupt lock.

Work is counted in slots of 8 clocks. The memory read port returns data in the same cycle as the request.

Top module: `tbl_line_dma`

## Requirements
- R1: While reset is held and after it is released, `busy`, `irq_lock`, `mem_rd`, `b_wr` and `burst_cancel` are all low.
- R2: On init, the enabled channels are handled in ascending channel order. For each one:
  - its table pointer is loaded from its source address;
  - its line-count byte is read at {source bank, pointer};
  - the pointer is incremented after the read.
- R3: A line-count byte of zero marks the channel completed. `chan_active[i]` equals enabled and not completed. A completed channel makes no reads and no writes until a frame reset.
- R4: In indirect mode, the fetched entry continues with pointer bytes read at {source bank, pointer}, with the pointer incremented after each byte.
  - The first byte goes to the high half of the data pointer.
  - A second byte is read only when the channel is not completed, or when some higher-numbered channel is active.
  - When the second byte is read, the first byte moves to the low half and the second byte becomes the high half.
- R5: The first pass of a run handles, in ascending order, each active channel whose transfer is pending. It moves a unit of bytes whose length depends on the 3-bit mode: modes 0 to 7 give 1, 2, 2, 4, 4, 4, 2 and 4 bytes.
- R6: The k-th byte of a unit is written to the B address (B base + offset). The offset depends on the mode:
  - 0 for modes 0, 2 and 6;
  - k mod 2 for modes 1 and 5;
  - k div 2 for modes 3 and 7;
  - k for mode 4.
  
  The written data is the byte just read.
- R7: Unit bytes are read from {source bank, table pointer} in direct mode, and from {indirect bank, data pointer} in indirect mode. The pointer used is incremented after each byte.
- R8: The second pass of a run handles every active channel in ascending order. It decrements the line counter and sets pending to bit 7 of the new value. A new entry fetch follows (as in R2/R4) when bits 6..0 of the new value are zero.
- R9: `busy` stays high for exactly 8 clocks times the number of slots, starting the cycle after the command is accepted. The command itself is one slot. Each memory read is one slot. Each second-pass channel that does not fetch is one slot.
- R10: `irq_lock` rises in the cycle in which `busy` falls and stays high for exactly 2 cycles.
- R11: In the cycle after a command is accepted, `burst_cancel` is high for one cycle.
  - For init, the mask is the enabled channels.
  - For run, the mask is the channels that are active at that point.
- R12: Commands are accepted only while `busy` is low. A command that arrives while `busy` is high is ignored. When init and run arrive together, init wins.
- R13: A `frame_rst` pulse while idle clears every completed flag and every pending flag. The pulse may arrive in the same cycle as a command, and the command then sees the cleared flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_rst | input | 1 | Frame reset of the completed and pending flags |
| init_cmd | input | 1 | Frame-start init command |
| run_cmd | input | 1 | Per-line run command |
| ch_en | input | NCH | Per-channel table enable |
| ch_indirect | input | NCH | Per-channel indirect mode |
| ch_mode | input | 3*NCH | Per-channel unit mode |
| ch_src_addr | input | 16*NCH | Per-channel table start address |
| ch_src_bank | input | 8*NCH | Per-channel table bank |
| ch_ind_bank | input | 8*NCH | Per-channel indirect data bank |
| ch_b_base | input | 8*NCH | Per-channel B port base address |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 24 | Memory read address {bank, offset} |
| mem_rdata | input | 8 | Memory read data, valid in the strobe cycle |
| b_wr | output | 1 | B port write strobe |
| b_addr | output | 8 | B port address |
| b_data | output | 8 | B port write data |
| burst_cancel | output | NCH | One-cycle burst cancel mask |
| busy | output | 1 | Engine owns the datapath |
| irq_lock | output | 1 | Interrupt lock after a command |
| chan_active | output | NCH | Enabled and not completed |

## Verification
If the line counter or the pending flag holds a wrong value, a run on the wrong line shows too many or too few B writes. It also changes the length of `busy`, and it shows up on that same run command. If the table pointer or the indirect data pointer is wrong, the very next memory read goes to the wrong address, so the fault appears within a single slot. If a completed flag is wrong, `chan_active` and the set of reads diverge at the next command. The tightest case is the conditional second pointer byte, which depends on the state of higher-numbered channels. The bench drives that case directly, with a completed top channel and with all channels indirect.

// File: rtl/tbl_dma_pkg.sv
package tbl_dma_pkg;
    localparam int ADDR_W = 16;
    localparam int BANK_W = 8;
    localparam int DATA_W = 8;
    localparam int MODE_W = 3;

    typedef enum logic [2:0] {
        S_IDLE, S_OVH, S_FCNT, S_FPLO, S_FPHI, S_XFER, S_SKIP
    } st_t;

    typedef enum logic [1:0] {PH_INIT, PH_P1, PH_P2} ph_t;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] ind;
        logic [DATA_W-1:0] cnt;
        logic              done;
        logic              pend;
    } chan_t;

    // last byte index of a unit for a mode
    function automatic logic [1:0] unit_last(input logic [MODE_W-1:0] m);
        case (m)
            3'd0:                  return 2'd0;
            3'd1, 3'd2, 3'd6:      return 2'd1;
            default:               return 2'd3;
        endcase
    endfunction

    // B address offset of byte k within a unit
    function automatic logic [1:0] b_offset(input logic [MODE_W-1:0] m, input logic [1:0] k);
        case (m)
            3'd1, 3'd5: return {1'b0, k[0]};
            3'd3, 3'd7: return {1'b0, k[1]};
            3'd4:       return k;
            default:    return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/tbl_pick.sv
module tbl_pick #(
    parameter int NCH = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask,
    input  logic [CHW:0]   start,
    output logic           hit,
    output logic [CHW-1:0] idx
);
    // lowest set bit of mask at or above start
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i] && ((CHW+1)'(i) >= start)) begin
                hit = 1'b1;
                idx = i[CHW-1:0];
            end
        end
    end
endmodule

// File: rtl/tbl_timer.sv
module tbl_timer #(
    parameter int SLOT_CLKS = 8,
    parameter int LOCK_CLKS = 2,
    localparam int SCW = $clog2(SLOT_CLKS),
    localparam int LKW = $clog2(LOCK_CLKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic lock_go,
    output logic act,
    output logic lock
);
    logic [SCW-1:0] scnt;
    logic [LKW-1:0] lcnt;

    assign act  = run && (scnt == SCW'(SLOT_CLKS - 1));
    assign lock = (lcnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            scnt <= '0;
            lcnt <= '0;
        end else begin
            if (!run || act) scnt <= '0;
            else             scnt <= scnt + 1'b1;
            if (lock_go)     lcnt <= LKW'(LOCK_CLKS);
            else if (lock)   lcnt <= lcnt - 1'b1;
        end
    end
endmodule

// File: rtl/tbl_line_dma.sv
module tbl_line_dma
    import tbl_dma_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int SLOT_CLKS = 8,
    parameter int LOCK_CLKS = 2,
    localparam int CHW = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_rst,
    input  logic                     init_cmd,
    input  logic                     run_cmd,
    input  logic [NCH-1:0]           ch_en,
    input  logic [NCH-1:0]           ch_indirect,
    input  logic [NCH*MODE_W-1:0]    ch_mode,
    input  logic [NCH*ADDR_W-1:0]    ch_src_addr,
    input  logic [NCH*BANK_W-1:0]    ch_src_bank,
    input  logic [NCH*BANK_W-1:0]    ch_ind_bank,
    input  logic [NCH*DATA_W-1:0]    ch_b_base,
    output logic                     mem_rd,
    output logic [BANK_W+ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic                     b_wr,
    output logic [DATA_W-1:0]        b_addr,
    output logic [DATA_W-1:0]        b_data,
    output logic [NCH-1:0]           burst_cancel,
    output logic                     busy,
    output logic                     irq_lock,
    output logic [NCH-1:0]           chan_active
);
    logic [MODE_W-1:0] mode_a  [NCH];
    logic [ADDR_W-1:0] base_a  [NCH];
    logic [BANK_W-1:0] bank_a  [NCH];
    logic [BANK_W-1:0] ibank_a [NCH];
    logic [DATA_W-1:0] boff_a  [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign mode_a[g]  = ch_mode[g*MODE_W +: MODE_W];
        assign base_a[g]  = ch_src_addr[g*ADDR_W +: ADDR_W];
        assign bank_a[g]  = ch_src_bank[g*BANK_W +: BANK_W];
        assign ibank_a[g] = ch_ind_bank[g*BANK_W +: BANK_W];
        assign boff_a[g]  = ch_b_base[g*DATA_W +: DATA_W];
    end

    chan_t          cs [NCH];
    st_t            st;
    ph_t            ph;
    logic [CHW-1:0] ch;
    logic [1:0]     bidx;
    logic [NCH-1:0] cancel_q;
    logic           act;
    logic           lock_go;

    // channel masks
    logic [NCH-1:0] act_m, p1_m;
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            act_m[i] = ch_en[i] && !cs[i].done;
            p1_m[i]  = act_m[i] && cs[i].pend;
        end
    end

    logic [CHW:0]   ch_nx;
    logic [NCH-1:0] pa_mask;
    logic [CHW:0]   pa_start;
    logic           pa_hit, pb_hit;
    logic [CHW-1:0] pa_idx, pb_idx;

    assign ch_nx    = {1'b0, ch} + 1'b1;
    assign pa_start = (st == S_OVH) ? '0 : ch_nx;
    assign pa_mask  = (ph == PH_INIT) ? ch_en : (ph == PH_P1) ? p1_m : act_m;

    tbl_pick #(.NCH(NCH)) u_pick_a (.mask(pa_mask), .start(pa_start), .hit(pa_hit), .idx(pa_idx));
    tbl_pick #(.NCH(NCH)) u_pick_b (.mask(act_m), .start('0), .hit(pb_hit), .idx(pb_idx));

    // where to go once the current channel (or the overhead slot) is finished
    st_t            r_st;
    ph_t            r_ph;
    logic [CHW-1:0] r_ch;
    logic           r_dec, r_lock;
    logic [DATA_W-1:0] dec_val;

    always_comb begin
        r_st   = S_IDLE;
        r_ph   = ph;
        r_ch   = ch;
        r_dec  = 1'b0;
        r_lock = 1'b0;
        if (pa_hit) begin
            r_ch = pa_idx;
            case (ph)
                PH_INIT: r_st  = S_FCNT;
                PH_P1:   r_st  = S_XFER;
                default: r_dec = 1'b1;
            endcase
        end else if (ph == PH_P1 && pb_hit) begin
            r_ph  = PH_P2;
            r_ch  = pb_idx;
            r_dec = 1'b1;
        end else begin
            r_lock = 1'b1;
        end
        dec_val = cs[r_ch].cnt - 1'b1;
        if (r_dec) r_st = (dec_val[6:0] == '0) ? S_FCNT : S_SKIP;
    end

    // current channel datapath
    chan_t cur;
    logic  last_byte, above_active, second_ptr, route_now;

    assign cur          = cs[ch];
    assign last_byte    = (bidx == unit_last(mode_a[ch]));
    assign above_active = |(act_m >> ch_nx);
    assign second_ptr   = !cur.done || above_active;

    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = {bank_a[ch], cur.ptr};
        case (st)
            S_FCNT, S_FPLO, S_FPHI: mem_rd = act;
            S_XFER: begin
                mem_rd = act;
                if (ch_indirect[ch]) mem_addr = {ibank_a[ch], cur.ind};
            end
            default: ;
        endcase
    end

    assign b_wr   = act && (st == S_XFER);
    assign b_addr = boff_a[ch] + DATA_W'(b_offset(mode_a[ch], bidx));
    assign b_data = mem_rdata;

    always_comb begin
        route_now = 1'b0;
        if (act) begin
            case (st)
                S_OVH, S_SKIP, S_FPHI: route_now = 1'b1;
                S_FCNT:                route_now = !ch_indirect[ch];
                S_FPLO:                route_now = !second_ptr;
                S_XFER:                route_now = last_byte;
                default:               route_now = 1'b0;
            endcase
        end
    end

    assign lock_go = route_now && r_lock;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            ph       <= PH_INIT;
            ch       <= '0;
            bidx     <= '0;
            cancel_q <= '0;
            for (int i = 0; i < NCH; i++) cs[i] <= '0;
        end else begin
            cancel_q <= '0;
            if (st == S_IDLE) begin
                if (frame_rst) begin
                    for (int i = 0; i < NCH; i++) begin
                        cs[i].done <= 1'b0;
                        cs[i].pend <= 1'b0;
                    end
                end
                if (init_cmd) begin
                    st       <= S_OVH;
                    ph       <= PH_INIT;
                    cancel_q <= ch_en;
                    for (int i = 0; i < NCH; i++)
                        if (ch_en[i]) cs[i].ptr <= base_a[i];
                end else if (run_cmd) begin
                    st       <= S_OVH;
                    ph       <= PH_P1;
                    cancel_q <= frame_rst ? ch_en : act_m;
                end
            end else if (act) begin
                case (st)
                    S_FCNT: begin
                        cs[ch].cnt  <= mem_rdata;
                        cs[ch].ptr  <= cur.ptr + 1'b1;
                        cs[ch].done <= (mem_rdata == '0);
                        cs[ch].pend <= (mem_rdata != '0);
                        if (ch_indirect[ch]) st <= S_FPLO;
                    end
                    S_FPLO: begin
                        cs[ch].ind <= {mem_rdata, 8'h00};
                        cs[ch].ptr <= cur.ptr + 1'b1;
                        if (second_ptr) st <= S_FPHI;
                    end
                    S_FPHI: begin
                        cs[ch].ind <= {mem_rdata, cur.ind[ADDR_W-1:8]};
                        cs[ch].ptr <= cur.ptr + 1'b1;
                    end
                    S_XFER: begin
                        if (ch_indirect[ch]) cs[ch].ind <= cur.ind + 1'b1;
                        else                 cs[ch].ptr <= cur.ptr + 1'b1;
                        bidx <= bidx + 1'b1;
                    end
                    default: ;
                endcase
                if (route_now) begin
                    st   <= r_st;
                    ph   <= r_ph;
                    ch   <= r_ch;
                    bidx <= '0;
                    if (r_dec) begin
                        cs[r_ch].cnt  <= dec_val;
                        cs[r_ch].pend <= dec_val[7];
                    end
                end
            end
        end
    end

    tbl_timer #(.SLOT_CLKS(SLOT_CLKS), .LOCK_CLKS(LOCK_CLKS)) u_timer (
        .clk(clk), .rst(rst), .run(st != S_IDLE), .lock_go(lock_go),
        .act(act), .lock(irq_lock)
    );

    assign busy         = (st != S_IDLE);
    assign burst_cancel = cancel_q;
    assign chan_active  = act_m;
endmodule

// File: rtl/tbl_line_dma_chk.sv
module tbl_line_dma_chk #(
    parameter int NCH       = 8,
    parameter int LOCK_CLKS = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           busy,
    input logic           irq_lock,
    input logic           mem_rd,
    input logic           b_wr,
    input logic [NCH-1:0] burst_cancel
);
    logic [7:0] lk_run;
    always_ff @(posedge clk) begin
        if (rst)           lk_run <= '0;
        else if (irq_lock) lk_run <= (lk_run == 8'hff) ? lk_run : lk_run + 1'b1;
        else               lk_run <= '0;
    end

    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !b_wr));

    a_r6_write_follows_read: assert property (@(posedge clk) disable iff (rst)
        b_wr |-> mem_rd);

    a_r11_cancel_at_start: assert property (@(posedge clk) disable iff (rst)
        (|burst_cancel) |-> $rose(busy));

    a_r10_lock_on_finish: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq_lock);

    a_r10_lock_length: assert property (@(posedge clk) disable iff (rst)
        irq_lock |-> (lk_run < LOCK_CLKS));
endmodule

bind tbl_line_dma tbl_line_dma_chk #(.NCH(NCH), .LOCK_CLKS(LOCK_CLKS)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .irq_lock(irq_lock),
    .mem_rd(mem_rd), .b_wr(b_wr), .burst_cancel(burst_cancel)
);

// File: tb/sim_tbl_line_dma.sv
module sim_tbl_line_dma;
    localparam int N = 8;
    localparam int SLOT = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_rst = 1'b0, init_cmd = 1'b0, run_cmd = 1'b0;
    logic [N-1:0]   cfg_en = '0, cfg_ind = '0;
    logic [N*3-1:0] cfg_mode = '0;
    logic [N*16-1:0] cfg_src = '0;
    logic [N*8-1:0] cfg_bank = '0, cfg_ibank = '0, cfg_boff = '0;
    logic        mem_rd, b_wr, busy, irq_lock;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata, b_addr, b_data;
    logic [N-1:0] burst_cancel, chan_active;
    logic [7:0] mem [4096];

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr[11:0]] ^ mem_addr[23:16];

    tbl_line_dma u0 (
        .clk(clk), .rst(rst), .frame_rst(frame_rst), .init_cmd(init_cmd), .run_cmd(run_cmd),
        .ch_en(cfg_en), .ch_indirect(cfg_ind), .ch_mode(cfg_mode), .ch_src_addr(cfg_src),
        .ch_src_bank(cfg_bank), .ch_ind_bank(cfg_ibank), .ch_b_base(cfg_boff),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .b_wr(b_wr), .b_addr(b_addr), .b_data(b_data),
        .burst_cancel(burst_cancel), .busy(busy), .irq_lock(irq_lock), .chan_active(chan_active)
    );

    int nchk = 0, nfail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned a, input longint unsigned e);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, a, e);
        end
    endtask

    // ---------------- reference model ----------------
    bit [15:0] m_ptr [N];
    bit [15:0] m_ind [N];
    bit [7:0]  m_cnt [N];
    bit        m_done [N];
    bit        m_pend [N];
    int        slots;
    bit [23:0] q_rd [$];
    string     q_rdt [$];
    bit [15:0] q_bw [$];

    function automatic bit [7:0] rdm(input bit [23:0] a);
        return mem[a[11:0]] ^ a[23:16];
    endfunction

    function automatic bit m_act(input int i);
        return cfg_en[i] && !m_done[i];
    endfunction

    function automatic int ulen(input bit [2:0] m);
        if (m == 0) return 1;
        if (m == 1 || m == 2 || m == 6) return 2;
        return 4;
    endfunction

    function automatic int boffs(input bit [2:0] m, input int k);
        if (m == 1 || m == 5) return k % 2;
        if (m == 3 || m == 7) return k / 2;
        if (m == 4) return k;
        return 0;
    endfunction

    task automatic m_read(input bit [23:0] a, input string tag, output bit [7:0] d);
        q_rd.push_back(a);
        q_rdt.push_back(tag);
        d = rdm(a);
        slots++;
    endtask

    task automatic m_fetch(input int i, input string tag);
        bit [7:0] d;
        bit above;
        m_read({cfg_bank[i*8 +: 8], m_ptr[i]}, tag, d);
        m_ptr[i]++;
        m_cnt[i] = d;
        m_done[i] = (d == 0);
        m_pend[i] = (d != 0);
        if (cfg_ind[i]) begin
            m_read({cfg_bank[i*8 +: 8], m_ptr[i]}, "R4", d);
            m_ptr[i]++;
            m_ind[i] = {d, 8'h00};
            above = 0;
            for (int j = i + 1; j < N; j++) if (m_act(j)) above = 1;
            if (!m_done[i] || above) begin
                m_read({cfg_bank[i*8 +: 8], m_ptr[i]}, "R4", d);
                m_ptr[i]++;
                m_ind[i] = {d, m_ind[i][15:8]};
            end
        end
    endtask

    task automatic model(input bit is_init, input bit frst, output bit [N-1:0] cancel);
        bit [7:0] d;
        bit [23:0] a;
        slots = 1;
        if (frst) for (int i = 0; i < N; i++) begin m_done[i] = 0; m_pend[i] = 0; end
        cancel = '0;
        for (int i = 0; i < N; i++) cancel[i] = is_init ? cfg_en[i] : m_act(i);
        if (is_init) begin
            for (int i = 0; i < N; i++) if (cfg_en[i]) begin
                m_ptr[i] = cfg_src[i*16 +: 16];
                m_fetch(i, "R2");
            end
        end else begin
            for (int i = 0; i < N; i++) if (m_act(i) && m_pend[i]) begin
                for (int k = 0; k < ulen(cfg_mode[i*3 +: 3]); k++) begin
                    if (cfg_ind[i]) begin a = {cfg_ibank[i*8 +: 8], m_ind[i]}; m_ind[i]++; end
                    else            begin a = {cfg_bank[i*8 +: 8], m_ptr[i]};  m_ptr[i]++; end
                    m_read(a, "R7", d);
                    q_bw.push_back({8'(cfg_boff[i*8 +: 8] + 8'(boffs(cfg_mode[i*3 +: 3], k))), d});
                end
            end
            for (int i = 0; i < N; i++) if (m_act(i)) begin
                m_cnt[i]--;
                m_pend[i] = m_cnt[i][7];
                if (m_cnt[i][6:0] == 0) m_fetch(i, "R8");
                else slots++;
            end
        end
    endtask

    // ---------------- command driver and monitor ----------------
    task automatic do_cmd(input bit is_init, input bit frst, input bit both, input bit inject);
        bit [N-1:0] exp_cancel, exp_act;
        int n, lk;
        model(is_init, frst, exp_cancel);
        for (int i = 0; i < N; i++) exp_act[i] = m_act(i);
        @(negedge clk);
        init_cmd  = is_init;
        run_cmd   = !is_init || both;
        frame_rst = frst;
        @(negedge clk);
        init_cmd = 0; run_cmd = 0; frame_rst = 0;
        chk(burst_cancel == exp_cancel, "R11", "cancel mask", burst_cancel, exp_cancel);
        n = 0;
        while (busy && n < 5000) begin
            if (inject && n == 3) run_cmd = 1;
            if (inject && n == 4) run_cmd = 0;
            if (mem_rd) begin
                if (q_rd.size() == 0) chk(0, "R3", "unexpected read", mem_addr, 0);
                else begin
                    string t = q_rdt.pop_front();
                    bit [23:0] e = q_rd.pop_front();
                    chk(mem_addr == e, t, "read addr", mem_addr, e);
                end
            end
            if (b_wr) begin
                if (q_bw.size() == 0) chk(0, "R5", "unexpected B write", {b_addr, b_data}, 0);
                else begin
                    bit [15:0] e = q_bw.pop_front();
                    chk({b_addr, b_data} == e, "R6", "B addr/data", {b_addr, b_data}, e);
                end
            end
            n++;
            @(negedge clk);
        end
        run_cmd = 0;
        chk(n == SLOT * slots, "R9", "busy length", n, SLOT * slots);
        chk(q_rd.size() == 0, "R2", "missing reads", q_rd.size(), 0);
        chk(q_bw.size() == 0, "R5", "missing B writes", q_bw.size(), 0);
        q_rd.delete(); q_rdt.delete(); q_bw.delete();
        lk = 0;
        while (irq_lock && lk < 10) begin lk++; @(negedge clk); end
        chk(lk == 2, "R10", "lock length", lk, 2);
        chk(busy == 0, "R12", "no command taken while busy", busy, 0);
        chk(chan_active == exp_act, "R3", "active mask", chan_active, exp_act);
    endtask

    task automatic randomize_frame(input int f);
        for (int j = 0; j < 4096; j++) begin
            int r = $urandom % 6;
            if (r == 0)      mem[j] = 8'h00;
            else if (r == 1) mem[j] = 8'h01;
            else if (r == 2) mem[j] = 8'h81;
            else if (r == 3) mem[j] = 8'h82;
            else             mem[j] = 8'($urandom);
        end
        for (int i = 0; i < N; i++) begin
            cfg_mode[i*3 +: 3]   = 3'($urandom);
            cfg_src[i*16 +: 16]  = 16'($urandom);
            cfg_bank[i*8 +: 8]   = 8'($urandom);
            cfg_ibank[i*8 +: 8]  = 8'($urandom);
            cfg_boff[i*8 +: 8]   = 8'($urandom);
        end
        cfg_en  = N'($urandom);
        cfg_ind = N'($urandom);
        if (f == 0) begin
            // R4 corner: top channel indirect, completes at once, nothing above it
            cfg_en = 8'h81; cfg_ind = 8'h80;
            cfg_mode[0 +: 3] = 3'd3;
            mem[cfg_src[7*16 +: 16] & 16'h0fff] = cfg_bank[7*8 +: 8];
        end else if (f == 1) begin
            cfg_en = '1; cfg_ind = '1;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            m_ptr[i] = 0; m_ind[i] = 0; m_cnt[i] = 0; m_done[i] = 0; m_pend[i] = 0;
        end
        for (int j = 0; j < 4096; j++) mem[j] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!busy && !irq_lock && !mem_rd && !b_wr && burst_cancel == 0, "R1", "in reset",
            {busy, irq_lock, mem_rd, b_wr}, 0);
        rst = 0;
        @(negedge clk);
        chk(!busy && !irq_lock && !mem_rd && !b_wr && burst_cancel == 0, "R1", "after reset",
            {busy, irq_lock, mem_rd, b_wr}, 0);
        for (int f = 0; f < 5; f++) begin
            randomize_frame(f);
            // R13 frame reset with init; R12 init wins when f == 2
            do_cmd(1, 1, f == 2, 0);
            if (f == 0)
                chk(chan_active[7] == 0, "R4", "top channel completed", chan_active[7], 0);
            for (int r = 0; r < 25; r++)
                do_cmd(0, 0, 0, (r % 5) == 2);
        end
        // R13: frame reset coinciding with a run revives completed channels
        do_cmd(0, 1, 0, 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog timeout actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule